// File: doc/BRIEF.md
# Pipelined Program-Address Sequencer

This block drives the program memory address of a small microcontroller core and hands fetched instruction words to the execute stage. Each instruction cycle lasts four system clocks, counted by an internal phase counter. The fetch of the word at the current address overlaps the execution of the word fetched in the previous cycle. Straight-line code therefore completes one instruction per cycle. At the last phase of every cycle the sequencer picks the next 13-bit address. The candidates are the incremented address, a page-local load of the low byte, a jump or call target, the top of the return stack, or a fixed interrupt vector.

Any change of flow discards the word that was already fetched. The next cycle is then a dummy: the execute stage sees a no-operation word with `exec_valid` low and must create no side effects. Calls and accepted interrupts emit a push strobe carrying the resume address for the external stack. Returns emit a pop strobe.

The instruction stream toward the execute stage carries a valid flag and no ready. The execute stage cannot stall the sequencer and must take every word in the cycle it is offered, so the stream has no back-pressure. The control strobes, the target and low-byte fields, the stack top and the interrupt requests must be held steady for a whole instruction cycle. They are sampled at its last phase.

Top module: `prog_seq`

## Requirements
- R1: While reset is asserted, `imem_addr` is 0x0000, `cyc_phase` is 0, `exec_valid` is 0 and both stack strobes are 0. The first instruction cycle after reset is a dummy.
- R2: `cyc_phase` counts 0,1,2,3 and then wraps. `imem_addr`, `exec_insn` and `exec_valid` change only on the clock edge that ends phase 3.
- R3: With no transfer and no interrupt, the next address is the current address plus one, modulo 2^13. In the next cycle `exec_insn` equals the word read at the previous address and `exec_valid` is 1.
- R4: A skip from a valid executing instruction advances the address by one. The next cycle is a dummy: `exec_insn` is 0x0000 and `exec_valid` is 0.
- R5: A low-byte write replaces address bits 7..0 with `ctl_low_data`, keeps bits 12..8 of the current fetch address, and makes the next cycle a dummy.
- R6: A jump or call loads all 13 bits of `ctl_target` and makes the next cycle a dummy. A call also pulses `push_stb`, with `push_addr` equal to the fetch address of the cycle in which the call executed.
- R7: A return loads `stack_top`, makes the next cycle a dummy, and pulses `pop_stb`.
- R8: An interrupt request present at the end of a cycle forces the address to 0x0004 (external), 0x0008 (timer 0) or 0x000C (timer 1). External has priority over timer 0, and timer 0 over timer 1. The next cycle is a dummy, and `push_stb` pulses with `push_addr` equal to the fetch address that was abandoned.
- R9: An accepted interrupt overrides any transfer strobe of the executing instruction. When it does, no pop is issued and only the interrupt's push occurs.
- R10: During a dummy cycle all transfer strobes are ignored: the address increments and no push or pop occurs. Interrupts are still accepted in a dummy cycle.
- R11: Among transfer strobes, jump or call wins over return, return over low-byte write, and low-byte write over skip.
- R12: `push_stb` and `pop_stb` are single-clock pulses during phase 0 that follows the deciding edge, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 13 | Program memory fetch address |
| imem_rdata | input | 16 | Program memory word at `imem_addr` |
| exec_insn | output | 16 | Word presented to the execute stage |
| exec_valid | output | 1 | High when `exec_insn` is a real instruction |
| cyc_phase | output | 2 | Phase of the current instruction cycle |
| ctl_jump | input | 1 | Executing instruction is a jump |
| ctl_call | input | 1 | Executing instruction is a call |
| ctl_ret | input | 1 | Executing instruction is a return |
| ctl_skip | input | 1 | Skip condition met |
| ctl_low_wr | input | 1 | Executing instruction writes the low address byte |
| ctl_target | input | 13 | Jump or call target |
| ctl_low_data | input | 8 | Byte written to the low address byte |
| stack_top | input | 13 | Top entry of the return stack |
| irq_ext | input | 1 | External interrupt request |
| irq_t0 | input | 1 | Timer 0 overflow request |
| irq_t1 | input | 1 | Timer 1 overflow request |
| push_stb | output | 1 | Push resume address onto the stack |
| push_addr | output | 13 | Address to push |
| pop_stb | output | 1 | Pop the stack |

## Verification
The hardest situations to reach from the ports are the collisions. One is a transfer strobe arriving while a dummy cycle is executing. Another is an interrupt landing on the same boundary as a call or return. A third is a low-byte write issued just after the fetch address has crossed into a new page. The stimulus reaches these in three ways. It deliberately asserts strobes in the cycle right after each flush. It sweeps all seven interrupt request patterns, each with and without a simultaneous call and return. It jumps to the last word of a page, so the next low-byte write must take its upper bits from the page that follows.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // decoded flow-control strobes of the executing instruction
  typedef struct packed {
    logic jump;
    logic call;
    logic ret;
    logic low_wr;
    logic skip;
  } ctl_t;
endpackage

// File: rtl/seq_phase.sv
module seq_phase #(
  parameter int PHASES = 4,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  assign last = (phase == PH_W'(PHASES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     phase <= '0;
    else if (last)  phase <= '0;
    else            phase <= phase + 1'b1;
  end
endmodule

// File: rtl/seq_next_addr.sv
module seq_next_addr #(
  parameter int AW       = 13,
  parameter int LW       = 8,
  parameter int N_IRQ    = 3,
  parameter int VEC_STEP = 4
) (
  input  logic [AW-1:0]    pc,
  input  logic             ir_valid,
  input  seq_pkg::ctl_t    ctl,
  input  logic [AW-1:0]    target,
  input  logic [LW-1:0]    low_data,
  input  logic [AW-1:0]    stack_top,
  input  logic [N_IRQ-1:0] irq,
  output logic [AW-1:0]    nxt_pc,
  output logic             flush,
  output logic             push,
  output logic             pop
);
  logic          irq_hit;
  logic [AW-1:0] vec;

  // lowest index wins: the loop runs downward so it is written last
  always_comb begin
    irq_hit = 1'b0;
    vec     = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (irq[i]) begin
        irq_hit = 1'b1;
        vec     = AW'((i + 1) * VEC_STEP);
      end
    end
  end

  always_comb begin
    nxt_pc = pc + 1'b1;
    flush  = 1'b0;
    push   = 1'b0;
    pop    = 1'b0;
    if (irq_hit) begin
      nxt_pc = vec;
      flush  = 1'b1;
      push   = 1'b1;
    end else if (ir_valid) begin
      if (ctl.jump || ctl.call) begin
        nxt_pc = target;
        flush  = 1'b1;
        push   = ctl.call;
      end else if (ctl.ret) begin
        nxt_pc = stack_top;
        flush  = 1'b1;
        pop    = 1'b1;
      end else if (ctl.low_wr) begin
        nxt_pc = {pc[AW-1:LW], low_data};
        flush  = 1'b1;
      end else if (ctl.skip) begin
        flush  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_fetch_stage.sv
module seq_fetch_stage #(
  parameter int          AW       = 13,
  parameter int          IW       = 16,
  parameter logic [AW-1:0] RST_VEC = '0,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          last,
  input  logic [AW-1:0] nxt_pc,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [IW-1:0] rdata,
  output logic [AW-1:0] pc,
  output logic [IW-1:0] ir,
  output logic          ir_valid,
  output logic          push_stb,
  output logic [AW-1:0] push_addr,
  output logic          pop_stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= RST_VEC;
      ir        <= NOP_WORD;
      ir_valid  <= 1'b0;
      push_stb  <= 1'b0;
      pop_stb   <= 1'b0;
      push_addr <= '0;
    end else if (last) begin
      pc        <= nxt_pc;
      ir        <= flush ? NOP_WORD : rdata;
      ir_valid  <= !flush;
      push_stb  <= push;
      pop_stb   <= pop;
      push_addr <= pc;
    end else begin
      push_stb  <= 1'b0;
      pop_stb   <= 1'b0;
    end
  end
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int AW       = 13,
  parameter int IW       = 16,
  parameter int LW       = 8,
  parameter int PHASES   = 4,
  parameter int N_IRQ    = 3,
  parameter int VEC_STEP = 4,
  localparam int PH_W    = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   imem_addr,
  input  logic [IW-1:0]   imem_rdata,
  output logic [IW-1:0]   exec_insn,
  output logic            exec_valid,
  output logic [PH_W-1:0] cyc_phase,
  input  logic            ctl_jump,
  input  logic            ctl_call,
  input  logic            ctl_ret,
  input  logic            ctl_skip,
  input  logic            ctl_low_wr,
  input  logic [AW-1:0]   ctl_target,
  input  logic [LW-1:0]   ctl_low_data,
  input  logic [AW-1:0]   stack_top,
  input  logic            irq_ext,
  input  logic            irq_t0,
  input  logic            irq_t1,
  output logic            push_stb,
  output logic [AW-1:0]   push_addr,
  output logic            pop_stb
);
  seq_pkg::ctl_t ctl;
  logic          last, flush, push, pop;
  logic [AW-1:0] nxt_pc;
  logic [2:0]    irq;

  assign ctl = '{jump: ctl_jump, call: ctl_call, ret: ctl_ret,
                 low_wr: ctl_low_wr, skip: ctl_skip};
  assign irq = {irq_t1, irq_t0, irq_ext};

  seq_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(cyc_phase), .last(last)
  );

  seq_next_addr #(.AW(AW), .LW(LW), .N_IRQ(N_IRQ), .VEC_STEP(VEC_STEP)) u_next (
    .pc(imem_addr), .ir_valid(exec_valid), .ctl(ctl), .target(ctl_target),
    .low_data(ctl_low_data), .stack_top(stack_top), .irq(irq[N_IRQ-1:0]),
    .nxt_pc(nxt_pc), .flush(flush), .push(push), .pop(pop)
  );

  seq_fetch_stage #(.AW(AW), .IW(IW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .last(last), .nxt_pc(nxt_pc), .flush(flush),
    .push(push), .pop(pop), .rdata(imem_rdata), .pc(imem_addr),
    .ir(exec_insn), .ir_valid(exec_valid), .push_stb(push_stb),
    .push_addr(push_addr), .pop_stb(pop_stb)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int AW   = 13,
  parameter int PH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PH_W-1:0] cyc_phase,
  input logic [AW-1:0]   imem_addr,
  input logic            exec_valid,
  input logic            push_stb,
  input logic            pop_stb,
  input logic            ctl_jump,
  input logic            ctl_call,
  input logic            ctl_ret,
  input logic            ctl_skip,
  input logic            ctl_low_wr,
  input logic            irq_ext,
  input logic            irq_t0,
  input logic            irq_t1
);
  logic at_end, any_irq, any_ctl;
  assign at_end  = (cyc_phase == {PH_W{1'b1}});
  assign any_irq = irq_ext || irq_t0 || irq_t1;
  assign any_ctl = ctl_jump || ctl_call || ctl_ret || ctl_skip || ctl_low_wr;

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> (cyc_phase == $past(cyc_phase) + 1'b1));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> $stable(imem_addr));

  // R3
  seq_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !any_irq && (!exec_valid || !any_ctl)) |=>
      (imem_addr == $past(imem_addr) + 1'b1));

  // R4
  skip_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !any_irq && exec_valid && ctl_skip &&
     !ctl_jump && !ctl_call && !ctl_ret && !ctl_low_wr) |=> !exec_valid);

  // R8
  ext_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && irq_ext) |=> (imem_addr == AW'(4) && push_stb && !exec_valid));

  // R8
  t0_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !irq_ext && irq_t0) |=> (imem_addr == AW'(8)));

  // R10
  dummy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !exec_valid && !any_irq) |=> (!push_stb && !pop_stb));

  // R12
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_stb && pop_stb));

  // R12
  stb_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_stb || pop_stb) |-> (cyc_phase == '0));
endmodule

bind prog_seq seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_phase(cyc_phase), .imem_addr(imem_addr),
  .exec_valid(exec_valid), .push_stb(push_stb), .pop_stb(pop_stb),
  .ctl_jump(ctl_jump), .ctl_call(ctl_call), .ctl_ret(ctl_ret),
  .ctl_skip(ctl_skip), .ctl_low_wr(ctl_low_wr), .irq_ext(irq_ext),
  .irq_t0(irq_t0), .irq_t1(irq_t1)
);

// File: tb/sim_prog_seq.sv
`timescale 1ns/1ps
module sim_prog_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] imem_addr;
  logic [15:0] imem_rdata, exec_insn;
  logic        exec_valid;
  logic [1:0]  cyc_phase;
  logic        ctl_jump, ctl_call, ctl_ret, ctl_skip, ctl_low_wr;
  logic [12:0] ctl_target, stack_top, push_addr;
  logic [7:0]  ctl_low_data;
  logic        irq_ext, irq_t0, irq_t1;
  logic        push_stb, pop_stb;

  int total = 0;
  int bad   = 0;

  // expected state
  logic [12:0] e_pc;
  logic        e_valid;
  logic [15:0] e_insn;

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [12:0] a);
    return {3'b000, a} ^ 16'hA5C3;
  endfunction

  assign imem_rdata = mem_word(imem_addr);

  prog_seq u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .exec_insn(exec_insn), .exec_valid(exec_valid), .cyc_phase(cyc_phase),
    .ctl_jump(ctl_jump), .ctl_call(ctl_call), .ctl_ret(ctl_ret),
    .ctl_skip(ctl_skip), .ctl_low_wr(ctl_low_wr), .ctl_target(ctl_target),
    .ctl_low_data(ctl_low_data), .stack_top(stack_top), .irq_ext(irq_ext),
    .irq_t0(irq_t0), .irq_t1(irq_t1), .push_stb(push_stb),
    .push_addr(push_addr), .pop_stb(pop_stb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one instruction cycle; called at a negedge with phase 0
  // ctl bits: {jump, call, ret, low_wr, skip}; irq bits: {t1, t0, ext}
  task automatic cyc(input string tag, input logic [4:0] c, input logic [12:0] tgt,
                     input logic [7:0] ld, input logic [12:0] st, input logic [2:0] irq);
    logic [12:0] old_pc, n_pc;
    logic        fl, ps, pp;
    {ctl_jump, ctl_call, ctl_ret, ctl_low_wr, ctl_skip} = c;
    ctl_target = tgt; ctl_low_data = ld; stack_top = st;
    {irq_t1, irq_t0, irq_ext} = irq;
    old_pc = e_pc;
    n_pc = old_pc + 13'd1; fl = 1'b0; ps = 1'b0; pp = 1'b0;
    if (irq != 3'b000) begin
      n_pc = irq[0] ? 13'h0004 : (irq[1] ? 13'h0008 : 13'h000C);
      fl = 1'b1; ps = 1'b1;
    end else if (e_valid) begin
      if (c[4] || c[3]) begin n_pc = tgt; fl = 1'b1; ps = c[3]; end
      else if (c[2]) begin n_pc = st; fl = 1'b1; pp = 1'b1; end
      else if (c[1]) begin n_pc = {old_pc[12:8], ld}; fl = 1'b1; end
      else if (c[0]) fl = 1'b1;
    end
    for (int k = 1; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R2 phase", 32'(cyc_phase), k);
      chk("R2 hold", 32'(imem_addr), 32'(old_pc));
    end
    @(posedge clk); @(negedge clk);
    e_pc = n_pc; e_valid = !fl; e_insn = fl ? 16'h0000 : mem_word(old_pc);
    chk({tag, " addr"},  32'(imem_addr),  32'(e_pc));
    chk({tag, " valid"}, 32'(exec_valid), 32'(e_valid));
    chk({tag, " insn"},  32'(exec_insn),  32'(e_insn));
    chk({tag, " R12 push"}, 32'(push_stb), 32'(ps));
    chk({tag, " R12 pop"},  32'(pop_stb),  32'(pp));
    if (ps) chk({tag, " push_addr"}, 32'(push_addr), 32'(old_pc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ctl_jump, ctl_call, ctl_ret, ctl_low_wr, ctl_skip} = '0;
    ctl_target = '0; ctl_low_data = '0; stack_top = '0;
    {irq_t1, irq_t0, irq_ext} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 addr", 32'(imem_addr), 0);
    chk("R1 phase", 32'(cyc_phase), 0);
    chk("R1 valid", 32'(exec_valid), 0);
    chk("R1 strobes", 32'({push_stb, pop_stb}), 0);
    e_pc = '0; e_valid = 1'b0; e_insn = '0;
    rst_n = 1'b1;

    // R10 first cycle is a dummy: a jump strobe there is ignored
    cyc("R10", 5'b10000, 13'h0100, 8'h00, 13'h0, 3'b000);
    // R3 straight-line run
    for (int i = 0; i < 12; i++) cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    // R4 skip, then R10 strobes in the dummy are ignored
    cyc("R4", 5'b00001, 13'h0, 8'h0, 13'h0, 3'b000);
    cyc("R10", 5'b01100, 13'h0555, 8'h00, 13'h0AAA, 3'b000);
    cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    // R6 jump to page end, R5 low writes after a page crossing
    cyc("R6", 5'b10000, 13'h0AFF, 8'h0, 13'h0, 3'b000);
    cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    for (int v = 0; v < 256; v += 37) begin
      cyc("R5", 5'b00010, 13'h0, 8'(v), 13'h0, 3'b000);
      cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    end
    // R6 call with push, R7 return with pop
    cyc("R6", 5'b01000, 13'h1234, 8'h0, 13'h0, 3'b000);
    cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    cyc("R7", 5'b00100, 13'h0, 8'h0, 13'h0789, 3'b000);
    cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    // R11 priority among transfer strobes
    cyc("R11", 5'b10111, 13'h0321, 8'h44, 13'h0999, 3'b000);
    cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    cyc("R11", 5'b00111, 13'h0321, 8'h44, 13'h0999, 3'b000);
    cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    cyc("R11", 5'b00011, 13'h0321, 8'h44, 13'h0999, 3'b000);
    cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    // R8 all request patterns, R9 with colliding call or return
    for (int p = 1; p < 8; p++) begin
      cyc("R8", 5'b00000, 13'h0, 8'h0, 13'h0, 3'(p));
      cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
      cyc("R9", 5'b01000, 13'h0F00, 8'h0, 13'h0, 3'(p));
      cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
      cyc("R9", 5'b00100, 13'h0, 8'h0, 13'h0E00, 3'(p));
      // R10 interrupt accepted during a dummy
      cyc("R10", 5'b00000, 13'h0, 8'h0, 13'h0, 3'(p));
      cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);
    end
    // R3 wrap at the top of the address space
    cyc("R6", 5'b10000, 13'h1FFE, 8'h0, 13'h0, 3'b000);
    for (int i = 0; i < 4; i++) cyc("R3", 5'b00000, 13'h0, 8'h0, 13'h0, 3'b000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule